// File: doc/BRIEF.md
# Gate-Matrix Circuit Fitness Evaluator

This block scores one candidate combinational circuit against a target truth table. The circuit is a grid of `ROWS` x `COLS` configurable cells. Each cell takes two selects and a gate kind. A cell in the first column reads the primary inputs, and a cell in any later column reads the outputs of the column to its left. Software loads the circuit one cell at a time through a write port. It loads the target outputs, one entry per input combination, through a second write port. It then pulses start.

The block walks every input combination in ascending order and evaluates the grid one column per clock. It compares the first `NOUT` rows of the last column with the target entry and adds one point for each matching bit. When the sweep ends it reports a fitness value with a one-cycle done pulse. A circuit that matches every bit counts as functional, and its fitness is raised by the number of pass-through cells it contains. A search loop running in software can therefore rank working circuits by how few real gates they use.

Top module: `gm_fitness_eval`

## Requirements
- R1: After reset, `done_o` is 0, `fitness_o` is 0, every cell holds code 0 with both selects 0, and every truth-table entry is 0.
- R2: A cell write stores `cell_cfg_i` at index `col*ROWS + row`, with column 0 nearest the inputs and row 0 first. Its fields are, from the MSB down: first select (`SELW` bits), second select (`SELW` bits), gate kind (3 bits). Indices at or above `ROWS*COLS` are dropped.
- R3: Gate kind codes: 0 is AND, 1 is OR, 2 is XOR, 3 is NOT of the first operand, 4 is WIRE, which passes the first operand through. Codes 5 to 7 behave and count as WIRE.
- R4: NOT and WIRE cells ignore their second select.
- R5: In column 0, a select value s below `NIN` reads bit s of the current input combination, and a value at or above `NIN` reads constant 0. In any later column, select s reads row s of the previous column.
- R6: The correctness score counts the matching bits over all `2^NIN` combinations. For each combination, bit o of the truth-table entry is compared with row o of the last column, for o from 0 to `NOUT-1`.
- R7: If the score equals `2^NIN * NOUT`, the fitness is that maximum plus the number of WIRE-class cells in the grid. Otherwise the fitness is the score.
- R8: Take the edge that samples `start_i` while the block is idle. `done_o` goes high for exactly one cycle right after the edge `2^NIN * COLS` cycles later, and `fitness_o` shows the new value in that same cycle.
- R9: `start_i` has no effect while an evaluation is running.
- R10: Cell and truth-table writes made while an evaluation is running are dropped.
- R11: `fitness_o` keeps its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an evaluation (ignored while running) |
| cell_we_i | input | 1 | Cell write strobe |
| cell_idx_i | input | CIDXW | Cell index, column-major |
| cell_cfg_i | input | 2*SELW+3 | Cell selects and gate kind |
| tt_we_i | input | 1 | Truth-table write strobe |
| tt_idx_i | input | NIN | Input combination being written |
| tt_row_i | input | NOUT | Target outputs for that combination |
| done_o | output | 1 | One-cycle completion pulse |
| fitness_o | output | FITW | Fitness of the last completed evaluation |

## Verification
The bench builds the block with 3 primary inputs, 2 outputs, 4 rows and 3 columns. This leaves row 3 of the first column with no input to read, so the constant-zero case of R5 can be reached. It also gives a full sweep of only 24 cycles, which makes it cheap to inject start pulses and writes in the middle of a run. Gate kinds are checked one at a time through circuits that are functional by design. A software model of the grid scores pseudo-random circuits and truth tables for comparison.

// File: rtl/gm_pkg.sv
package gm_pkg;
  typedef enum logic [2:0] {
    G_AND  = 3'd0,
    G_OR   = 3'd1,
    G_XOR  = 3'd2,
    G_NOT  = 3'd3,
    G_WIRE = 3'd4
  } gate_e;

  // codes 4..7 are all pass-through
  function automatic logic is_wire(logic [2:0] kind);
    return kind[2];
  endfunction
endpackage

// File: rtl/gm_cell.sv
module gm_cell
  import gm_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int SELW = 2
) (
  input  logic [ROWS-1:0] col_i,
  input  logic [SELW-1:0] sel_a_i,
  input  logic [SELW-1:0] sel_b_i,
  input  logic [2:0]      kind_i,
  output logic            y_o
);
  logic a, b;

  always_comb begin
    a = (int'(sel_a_i) < ROWS) ? col_i[sel_a_i] : 1'b0;
    b = (int'(sel_b_i) < ROWS) ? col_i[sel_b_i] : 1'b0;
    case (kind_i)
      G_AND:   y_o = a & b;
      G_OR:    y_o = a | b;
      G_XOR:   y_o = a ^ b;
      G_NOT:   y_o = ~a;
      default: y_o = a;
    endcase
  end
endmodule

// File: rtl/gm_column.sv
module gm_column #(
  parameter int ROWS  = 4,
  parameter int SELW  = 2,
  parameter int CELLW = 2 * SELW + 3
) (
  input  logic [ROWS-1:0]       col_i,
  input  logic [ROWS*CELLW-1:0] cfg_i,
  output logic [ROWS-1:0]       col_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [CELLW-1:0] c;
    assign c = cfg_i[r*CELLW +: CELLW];
    gm_cell #(.ROWS(ROWS), .SELW(SELW)) u_cell (
      .col_i  (col_i),
      .sel_a_i(c[CELLW-1 -: SELW]),
      .sel_b_i(c[CELLW-1-SELW -: SELW]),
      .kind_i (c[2:0]),
      .y_o    (col_o[r])
    );
  end
endmodule

// File: rtl/gm_fitness_eval.sv
module gm_fitness_eval
  import gm_pkg::*;
#(
  parameter int NIN  = 4,
  parameter int NOUT = 3,
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int SELW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CELLW = 2 * SELW + 3,
  localparam int NCELL = ROWS * COLS,
  localparam int CIDXW = (NCELL > 1) ? $clog2(NCELL) : 1,
  localparam int NCOMB = 1 << NIN,
  localparam int MAXSC = NCOMB * NOUT,
  localparam int FITW  = $clog2(MAXSC + NCELL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cell_we_i,
  input  logic [CIDXW-1:0] cell_idx_i,
  input  logic [CELLW-1:0] cell_cfg_i,
  input  logic             tt_we_i,
  input  logic [NIN-1:0]   tt_idx_i,
  input  logic [NOUT-1:0]  tt_row_i,
  output logic             done_o,
  output logic [FITW-1:0]  fitness_o
);
  localparam int COLW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int SCW  = $clog2(MAXSC + 1);
  localparam int MW   = $clog2(NOUT + 1);
  localparam int WCW  = $clog2(NCELL + 1);

  logic [CELLW-1:0] cfg_q [NCELL];
  logic [NOUT-1:0]  tt_q  [NCOMB];

  logic             busy_q, done_q;
  logic [NIN-1:0]   comb_q;
  logic [COLW-1:0]  col_q;
  logic [ROWS-1:0]  val_q;
  logic [SCW-1:0]   score_q;
  logic [FITW-1:0]  fit_q;

  logic [ROWS-1:0]       pin_w, col_in_w, col_out_w;
  logic [ROWS*CELLW-1:0] col_cfg_w;
  logic [MW-1:0]         match_cnt;
  logic [WCW-1:0]        wire_cnt;
  logic [SCW-1:0]        score_nx;
  logic [FITW-1:0]       fit_nx;
  logic                  last_col, last_comb;

  // configuration and target stores, writable only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCELL; i++) cfg_q[i] <= '0;
      for (int i = 0; i < NCOMB; i++) tt_q[i] <= '0;
    end else if (!busy_q) begin
      if (cell_we_i && int'(cell_idx_i) < NCELL) cfg_q[cell_idx_i] <= cell_cfg_i;
      if (tt_we_i) tt_q[tt_idx_i] <= tt_row_i;
    end
  end

  // primary inputs padded with zeros up to ROWS
  for (genvar r = 0; r < ROWS; r++) begin : g_pin
    if (r < NIN) begin : g_in
      assign pin_w[r] = comb_q[r];
    end else begin : g_zero
      assign pin_w[r] = 1'b0;
    end
  end

  assign col_in_w = (col_q == '0) ? pin_w : val_q;

  always_comb begin
    for (int r = 0; r < ROWS; r++)
      col_cfg_w[r*CELLW +: CELLW] = cfg_q[int'(col_q) * ROWS + r];
  end

  gm_column #(.ROWS(ROWS), .SELW(SELW), .CELLW(CELLW)) u_column (
    .col_i(col_in_w),
    .cfg_i(col_cfg_w),
    .col_o(col_out_w)
  );

  always_comb begin
    match_cnt = '0;
    for (int o = 0; o < NOUT; o++)
      match_cnt = match_cnt + MW'(col_out_w[o] == tt_q[comb_q][o]);
  end

  always_comb begin
    wire_cnt = '0;
    for (int i = 0; i < NCELL; i++)
      wire_cnt = wire_cnt + WCW'(is_wire(cfg_q[i][2:0]));
  end

  assign score_nx  = score_q + SCW'(match_cnt);
  assign fit_nx    = (score_nx == SCW'(MAXSC)) ? FITW'(MAXSC) + FITW'(wire_cnt)
                                               : FITW'(score_nx);
  assign last_col  = (int'(col_q) == COLS - 1);
  assign last_comb = (comb_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      comb_q  <= '0;
      col_q   <= '0;
      val_q   <= '0;
      score_q <= '0;
      fit_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          comb_q  <= '0;
          col_q   <= '0;
          score_q <= '0;
        end
      end else begin
        val_q <= col_out_w;
        if (last_col) begin
          col_q   <= '0;
          score_q <= score_nx;
          if (last_comb) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            fit_q  <= fit_nx;
          end else begin
            comb_q <= comb_q + 1'b1;
          end
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  assign done_o    = done_q;
  assign fitness_o = fit_q;
endmodule

// File: rtl/gm_fitness_eval_chk.sv
module gm_fitness_eval_chk #(
  parameter int NIN  = 4,
  parameter int NOUT = 3,
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int NCELL = ROWS * COLS,
  localparam int MAXSC = (1 << NIN) * NOUT,
  localparam int FITW  = $clog2(MAXSC + NCELL + 1),
  localparam int RUNC  = (1 << NIN) * COLS
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_i,
  input logic            done_i,
  input logic [FITW-1:0] fitness_i
);
  logic armed_q;
  int   lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      lat_q   <= 0;
    end else begin
      armed_q <= 1'b1;
      if (!busy_i && start_i) lat_q <= 0;
      else if (busy_i) lat_q <= lat_q + 1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);                                   // R8
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> lat_q == RUNC);                             // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);                                   // R9
  AST_FIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !done_i) |-> $stable(fitness_i));          // R11
  AST_FIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fitness_i) <= MAXSC + NCELL);                     // R7
endmodule

bind gm_fitness_eval gm_fitness_eval_chk #(
  .NIN(NIN), .NOUT(NOUT), .ROWS(ROWS), .COLS(COLS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_i   (busy_q),
  .done_i   (done_o),
  .fitness_i(fitness_o)
);

// File: tb/gm_fitness_eval_bench.sv
module gm_fitness_eval_bench;
  localparam int NIN = 3, NOUT = 2, ROWS = 4, COLS = 3;
  localparam int SELW = 2, CELLW = 7, NCELL = 12, CIDXW = 4;
  localparam int NCOMB = 8, MAXSC = 16, FITW = 5, RUNC = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, cell_we = 1'b0, tt_we = 1'b0;
  logic [CIDXW-1:0] cell_idx = '0;
  logic [CELLW-1:0] cell_cfg = '0;
  logic [NIN-1:0]   tt_idx = '0;
  logic [NOUT-1:0]  tt_row = '0;
  logic             done;
  logic [FITW-1:0]  fit;

  int n_chk = 0, n_fail = 0;
  logic [CELLW-1:0] m_cfg [NCELL];
  logic [NOUT-1:0]  m_tt  [NCOMB];
  int unsigned rs = 32'h1234_5678;

  always #2 clk = ~clk;

  gm_fitness_eval #(.NIN(NIN), .NOUT(NOUT), .ROWS(ROWS), .COLS(COLS)) u_gm_fitness_eval (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cell_we_i(cell_we), .cell_idx_i(cell_idx), .cell_cfg_i(cell_cfg),
    .tt_we_i(tt_we), .tt_idx_i(tt_idx), .tt_row_i(tt_row),
    .done_o(done), .fitness_o(fit)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  function automatic int model_fit();
    int sc = 0, wires = 0;
    for (int cb = 0; cb < NCOMB; cb++) begin
      logic [ROWS-1:0] v, nv;
      for (int r = 0; r < ROWS; r++) v[r] = (r < NIN) ? cb[r] : 1'b0;
      for (int c = 0; c < COLS; c++) begin
        for (int r = 0; r < ROWS; r++) begin
          logic [CELLW-1:0] e;
          logic a, b;
          e = m_cfg[c*ROWS + r];
          a = v[e[6:5]];
          b = v[e[4:3]];
          case (e[2:0])
            3'd0: nv[r] = a & b;
            3'd1: nv[r] = a | b;
            3'd2: nv[r] = a ^ b;
            3'd3: nv[r] = ~a;
            default: nv[r] = a;
          endcase
        end
        v = nv;
      end
      for (int o = 0; o < NOUT; o++) if (v[o] == m_tt[cb][o]) sc++;
    end
    for (int i = 0; i < NCELL; i++) if (m_cfg[i][2]) wires++;
    return (sc == MAXSC) ? MAXSC + wires : sc;
  endfunction

  task automatic put_cell(input int c, input int r, input int sa, input int sb, input int k);
    logic [CELLW-1:0] e;
    e = {2'(sa), 2'(sb), 3'(k)};
    m_cfg[c*ROWS + r] = e;
    @(negedge clk); cell_we = 1'b1; cell_idx = CIDXW'(c*ROWS + r); cell_cfg = e;
    @(negedge clk); cell_we = 1'b0;
  endtask

  task automatic put_tt(input int i, input int val);
    m_tt[i] = NOUT'(val);
    @(negedge clk); tt_we = 1'b1; tt_idx = NIN'(i); tt_row = NOUT'(val);
    @(negedge clk); tt_we = 1'b0;
  endtask

  task automatic load_identity();
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) put_cell(c, r, r, 0, 4);
  endtask

  // act: 0 none, 1 start pulse mid-run, 2 writes mid-run
  task automatic run_eval(input int poke_at, input int act, output int f, output int lat);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    lat = 0;
    f = -1;
    while (lat < 1000) begin
      @(posedge clk); lat++;
      @(negedge clk);
      start = 1'b0; cell_we = 1'b0; tt_we = 1'b0;
      if (done) begin f = int'(fit); break; end
      if (lat == poke_at && act == 1) start = 1'b1;
      if (lat == poke_at && act == 2) begin
        cell_we = 1'b1; cell_idx = '0; cell_cfg = {2'd1, 2'd1, 3'd3};
        tt_we = 1'b1; tt_idx = '0; tt_row = 2'b11;
      end
    end
    if (lat >= 1000) check("R8 done never seen", 0, 1);
  endtask

  task automatic t_reset();
    check("R1 done after reset", int'(done), 0);
    check("R1 fitness after reset", int'(fit), 0);
  endtask

  task automatic t_identity();
    int f, lat;
    load_identity();
    for (int i = 0; i < NCOMB; i++) put_tt(i, i & 3);
    run_eval(0, 0, f, lat);
    check("R7 identity functional", f, MAXSC + NCELL);
    check("R8 latency", lat, RUNC);
    @(negedge clk);
    check("R8 done single cycle", int'(done), 0);
    repeat (5) @(negedge clk);
    check("R11 fitness held", int'(fit), MAXSC + NCELL);
  endtask

  task automatic t_scores();
    int f, lat;
    for (int i = 0; i < NCOMB; i++) put_tt(i, ~i & 3);
    run_eval(0, 0, f, lat);
    check("R6 all bits wrong", f, 0);
    for (int i = 0; i < NCOMB; i++) put_tt(i, (~i & 2) | (i & 1));
    run_eval(0, 0, f, lat);
    check("R6 one output matches", f, 8);
  endtask

  task automatic t_double_not();
    int f, lat;
    load_identity();
    for (int i = 0; i < NCOMB; i++) put_tt(i, i & 3);
    put_cell(0, 0, 0, 0, 3);
    put_cell(1, 0, 0, 0, 3);
    run_eval(0, 0, f, lat);
    check("R7 wires counted", f, MAXSC + NCELL - 2);
    put_cell(0, 0, 0, 3, 3);
    put_cell(1, 0, 0, 2, 3);
    put_cell(1, 1, 1, 3, 4);
    put_cell(2, 1, 1, 2, 4);
    run_eval(0, 0, f, lat);
    check("R4 second select ignored", f, MAXSC + NCELL - 2);
  endtask

  task automatic t_gate_codes();
    int f, lat, exp_o;
    for (int k = 0; k < 8; k++) begin
      load_identity();
      put_cell(0, 0, 0, 1, k);
      for (int i = 0; i < NCOMB; i++) begin
        case (k)
          0: exp_o = i[0] & i[1];
          1: exp_o = i[0] | i[1];
          2: exp_o = i[0] ^ i[1];
          3: exp_o = ~i[0] & 1;
          default: exp_o = i[0];
        endcase
        put_tt(i, (i & 2) | exp_o);
      end
      run_eval(0, 0, f, lat);
      check($sformatf("R3 gate code %0d", k), f, MAXSC + NCELL - ((k < 4) ? 1 : 0));
    end
  endtask

  task automatic t_pad();
    int f, lat;
    load_identity();
    put_cell(0, 1, 3, 0, 4);
    for (int i = 0; i < NCOMB; i++) put_tt(i, i & 1);
    run_eval(0, 0, f, lat);
    check("R5 unused input row reads 0", f, MAXSC + NCELL);
    put_cell(0, 1, 2, 0, 4);
    for (int i = 0; i < NCOMB; i++) put_tt(i, (i & 4) >> 1 | (i & 1));
    run_eval(0, 0, f, lat);
    check("R5 select reads input bit 2", f, MAXSC + NCELL);
  endtask

  task automatic t_random();
    int f, lat;
    for (int n = 0; n < 8; n++) begin
      for (int c = 0; c < COLS; c++)
        for (int r = 0; r < ROWS; r++)
          put_cell(c, r, rnd() % 4, rnd() % 4, rnd() % 8);
      for (int i = 0; i < NCOMB; i++) put_tt(i, rnd() % 4);
      run_eval(0, 0, f, lat);
      check("R2 R6 random circuit vs model", f, model_fit());
    end
  endtask

  task automatic t_busy();
    int f, lat, exp_f, extra;
    load_identity();
    for (int i = 0; i < NCOMB; i++) put_tt(i, i & 3);
    exp_f = model_fit();
    run_eval(10, 1, f, lat);
    check("R9 start mid-run latency", lat, RUNC);
    check("R9 start mid-run fitness", f, exp_f);
    extra = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R9 no second run", extra, 0);
    run_eval(5, 2, f, lat);
    check("R10 writes while busy, this run", f, exp_f);
    run_eval(0, 0, f, lat);
    check("R10 writes while busy dropped", f, exp_f);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCELL; i++) m_cfg[i] = '0;
    for (int i = 0; i < NCOMB; i++) m_tt[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_scores();
    t_double_not();
    t_gate_codes();
    t_pad();
    t_random();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule